// File: doc/BRIEF.md
# MFM Write Stream Escape Decoder

This block sits in front of the bit-cell encoder of an MFM floppy write channel. It takes the byte stream meant for the disk and reads control commands carried in-band. The byte 0x99 opens an escape, and the byte after it picks the action. That action can be a literal 0x99, a mark byte to be written with a missing clock, a request to append the running CRC, the end of the write, or a pause of escape detection for one whole sector payload. Every other byte, including gap filler (0x4E) and sync zeros (0x00), goes through as plain data.

Input and output are both valid/ready byte streams. Each output byte carries a two-bit kind tag that tells the encoder how to write it: 0 = plain data, 1 = mark with a missing clock, 2 = CRC byte. A CRC-16 (polynomial 0x1021) is kept over the mark and data bytes of the current field. It is preset to 0xFFFF by the first mark of a run of marks. After a stop command the block drops its input and holds its write gate low until it receives a one-cycle `arm` pulse.

The controller has six states. `S_HALT` is stopped and leaves on `arm`. `S_PLAIN` passes bytes through and goes to `S_ESC` on 0x99. From `S_ESC` the next byte sends the block back to `S_PLAIN` (literal, mark, or unknown command), on to `S_CRC_HI`, to `S_HALT`, or to `S_RAW`. `S_RAW` returns to `S_PLAIN` after the last byte of the block. `S_CRC_HI` moves to `S_CRC_LO`, which returns to `S_PLAIN`.

Top module: `mfm_esc_decoder`

## Requirements
- R1: A byte 0x99 seen outside a raw block is never output itself. Each escape pair produces at most one output byte, and the output sequence holds exactly the bytes the rules below produce, in input order.
- R2: The pair 0x99 0x99 outputs one byte 0x99 with kind 0 (data).
- R3: The pairs 0x99 0xA1, 0x99 0xFB and 0x99 0xFE output the second byte with kind 1 (missing-clock mark).
- R4: The CRC is CRC-16 with polynomial 0x1021, shifted most significant bit first. It covers every data and mark byte that is output. It is preset to 0xFFFF before a mark byte whose previous output byte was not a mark. CRC bytes themselves are not included.
- R5: The pair 0x99 0x04 outputs the current CRC as two kind-2 bytes, high byte first. No input is accepted while these two bytes are produced.
- R6: The pair 0x99 0x08 drops `wr_gate` low. After that, input is accepted and discarded with no output until a one-cycle `arm` pulse, which raises `wr_gate` again. `arm` has no effect while writing.
- R7: The pair 0x99 0x0F makes the next RAW_LEN (default 512) bytes pass as kind-0 data with no escape decoding, 0x99 included. Decoding resumes after the last of them.
- R8: Any other byte after an escape is discarded and raises `err_cmd` for exactly one cycle, on the cycle after it is accepted.
- R9: A byte other than 0x99 outside an escape, such as gap 0x4E or sync 0x00, is output unchanged with kind 0.
- R10: After reset the block is stopped: `wr_gate` = 0, `out_valid` = 0, `err_cmd` = 0, and input is accepted and dropped.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_kind` hold their values and `in_ready` is low in the pass-through states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| arm | input | 1 | One-cycle pulse that restarts writing after a stop |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_kind | output | 2 | 0 data, 1 missing-clock mark, 2 CRC byte |
| out_ready | input | 1 | Encoder takes the output byte this cycle |
| err_cmd | output | 1 | Pulse: unknown command after escape |
| wr_gate | output | 1 | High while the write is active |

## Verification
The assertions assume that the encoder follows valid/ready: once `out_valid` is high, the block itself must not change the byte until `out_ready` takes it. They also assume that `arm` arrives only as a single-cycle pulse. The bench drives `arm` only while the block is stopped, one cycle at a time, and changes `out_ready` and `in_valid` only between clock edges. Random back-pressure and input gaps exercise stalls in every state, the CRC emission states included. Each stream ends with a stop command followed by bytes that must be dropped.

// File: rtl/mfm_esc_pkg.sv
package mfm_esc_pkg;

    typedef enum logic [2:0] {
        S_HALT   = 3'd0,
        S_PLAIN  = 3'd1,
        S_ESC    = 3'd2,
        S_RAW    = 3'd3,
        S_CRC_HI = 3'd4,
        S_CRC_LO = 3'd5
    } esc_state_t;

    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_MARK = 2'd1,
        K_CRC  = 2'd2
    } byte_kind_t;

    localparam logic [7:0] B_ESCAPE   = 8'h99;
    localparam logic [7:0] B_SYNCMARK = 8'hA1;
    localparam logic [7:0] B_DATAMARK = 8'hFB;
    localparam logic [7:0] B_ADDRMARK = 8'hFE;
    localparam logic [7:0] C_PUT_CRC  = 8'h04;
    localparam logic [7:0] C_STOP     = 8'h08;
    localparam logic [7:0] C_RAWBLK   = 8'h0F;

endpackage

// File: rtl/mfm_crc16.sv
module mfm_crc16 #(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] INIT = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd,
    input  logic        preset,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    function automatic logic [15:0] step(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        return c;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= INIT;
        else if (upd) crc <= step(preset ? INIT : crc, din);
    end

    // R4
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(crc));

endmodule

// File: rtl/mfm_raw_count.sv
module mfm_raw_count #(
    parameter int LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= last ? '0 : cnt + 1'b1;
    end

    assign last = (cnt == CW'(LEN - 1));

    // R7
    raw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LEN - 1));

endmodule

// File: rtl/mfm_esc_fsm.sv
module mfm_esc_fsm
    import mfm_esc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    input  logic        arm,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic [1:0]  out_kind,
    input  logic        out_ready,
    output logic        err_cmd,
    output logic        wr_gate,
    output logic        crc_upd,
    output logic        crc_preset,
    output logic [7:0]  crc_din,
    input  logic [15:0] crc_val,
    output logic        raw_clr,
    output logic        raw_inc,
    input  logic        raw_last
);

    esc_state_t state, state_d;
    logic       mark_run, mark_run_d;
    logic       slot_free, accept;
    logic       emit, cmd_bad;
    logic [7:0] e_data;
    byte_kind_t e_kind;

    assign slot_free = !out_valid || out_ready;

    always_comb begin
        unique case (state)
            S_HALT:                in_ready = 1'b1;
            S_PLAIN, S_ESC, S_RAW: in_ready = slot_free;
            default:               in_ready = 1'b0;
        endcase
    end

    assign accept  = in_valid && in_ready;
    assign wr_gate = (state != S_HALT);

    // next state and the byte to emit
    always_comb begin
        state_d    = state;
        mark_run_d = mark_run;
        emit       = 1'b0;
        e_data     = in_data;
        e_kind     = K_DATA;
        cmd_bad    = 1'b0;
        raw_clr    = 1'b0;
        raw_inc    = 1'b0;
        unique case (state)
            S_HALT: begin
                if (arm) begin
                    state_d    = S_PLAIN;
                    mark_run_d = 1'b0;
                end
            end
            S_PLAIN: begin
                if (accept) begin
                    if (in_data == B_ESCAPE) state_d = S_ESC;
                    else                     emit    = 1'b1;
                end
            end
            S_ESC: begin
                if (accept) begin
                    state_d = S_PLAIN;
                    case (in_data)
                        B_ESCAPE: emit = 1'b1;
                        B_SYNCMARK, B_DATAMARK, B_ADDRMARK: begin
                            emit   = 1'b1;
                            e_kind = K_MARK;
                        end
                        C_PUT_CRC: state_d = S_CRC_HI;
                        C_STOP:    state_d = S_HALT;
                        C_RAWBLK: begin
                            state_d = S_RAW;
                            raw_clr = 1'b1;
                        end
                        default:   cmd_bad = 1'b1;
                    endcase
                end
            end
            S_RAW: begin
                if (accept) begin
                    emit    = 1'b1;
                    raw_inc = 1'b1;
                    if (raw_last) state_d = S_PLAIN;
                end
            end
            S_CRC_HI: begin
                if (slot_free) begin
                    emit    = 1'b1;
                    e_data  = crc_val[15:8];
                    e_kind  = K_CRC;
                    state_d = S_CRC_LO;
                end
            end
            S_CRC_LO: begin
                if (slot_free) begin
                    emit    = 1'b1;
                    e_data  = crc_val[7:0];
                    e_kind  = K_CRC;
                    state_d = S_PLAIN;
                end
            end
            default: state_d = S_HALT;
        endcase
        if (emit) mark_run_d = (e_kind == K_MARK);
    end

    assign crc_upd    = emit && (e_kind != K_CRC);
    assign crc_preset = (e_kind == K_MARK) && !mark_run;
    assign crc_din    = e_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_HALT;
            mark_run <= 1'b0;
        end else begin
            state    <= state_d;
            mark_run <= mark_run_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_kind  <= K_DATA;
            err_cmd   <= 1'b0;
        end else begin
            err_cmd <= cmd_bad;
            if (emit) begin
                out_valid <= 1'b1;
                out_data  <= e_data;
                out_kind  <= e_kind;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_kind)));

    // R5
    crc_noaccept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CRC_HI || state == S_CRC_LO) |-> !in_ready);

    // R8
    err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cmd |-> ($past(state) == S_ESC) && wr_gate);

    // R6
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_gate && !out_valid) |=> !out_valid);

    // R7
    raw_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RAW && accept && raw_last) |=> (state == S_PLAIN));

endmodule

// File: rtl/mfm_esc_decoder.sv
module mfm_esc_decoder #(
    parameter int          RAW_LEN  = 512,
    parameter logic [15:0] CRC_POLY = 16'h1021,
    parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       arm,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic [1:0] out_kind,
    input  logic       out_ready,
    output logic       err_cmd,
    output logic       wr_gate
);

    logic        crc_upd, crc_preset;
    logic [7:0]  crc_din;
    logic [15:0] crc_val;
    logic        raw_clr, raw_inc, raw_last;

    mfm_esc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .arm        (arm),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_kind   (out_kind),
        .out_ready  (out_ready),
        .err_cmd    (err_cmd),
        .wr_gate    (wr_gate),
        .crc_upd    (crc_upd),
        .crc_preset (crc_preset),
        .crc_din    (crc_din),
        .crc_val    (crc_val),
        .raw_clr    (raw_clr),
        .raw_inc    (raw_inc),
        .raw_last   (raw_last)
    );

    mfm_crc16 #(
        .POLY (CRC_POLY),
        .INIT (CRC_INIT)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (crc_upd),
        .preset (crc_preset),
        .din    (crc_din),
        .crc    (crc_val)
    );

    mfm_raw_count #(
        .LEN (RAW_LEN)
    ) u_raw (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (raw_clr),
        .inc   (raw_inc),
        .last  (raw_last)
    );

endmodule

// File: tb/sim_mfm_esc_decoder.sv
module sim_mfm_esc_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int RAW_LEN    = 512;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       arm = 1'b0;
    logic       out_ready = 1'b0;
    logic       in_ready, out_valid, err_cmd, wr_gate;
    logic [7:0] out_data;
    logic [1:0] out_kind;

    mfm_esc_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .arm(arm), .out_valid(out_valid), .out_data(out_data),
        .out_kind(out_kind), .out_ready(out_ready), .err_cmd(err_cmd), .wr_gate(wr_gate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] stim[$];
    logic [7:0] ed[$];
    logic [1:0] ek[$];
    logic [7:0] gd[$];
    logic [1:0] gk[$];
    int e_err, g_err;
    logic [15:0] ref_crc = 16'hFFFF;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        c = c_in ^ {d, 8'h00};
        for (int i = 0; i < 8; i++)
            c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        return c;
    endfunction

    function automatic string kind_req(input logic [1:0] k);
        if (k == 2'd1) return "R3";
        if (k == 2'd2) return "R5";
        return "R9";
    endfunction

    // reference: 0 plain, 1 after escape, 2 raw block, 3 stopped
    task automatic build_expect();
        int  mode = 0;
        int  cnt = 0;
        bit  run = 0;
        ed.delete(); ek.delete(); e_err = 0;
        foreach (stim[i]) begin
            logic [7:0] b;
            b = stim[i];
            case (mode)
                0: if (b == 8'h99) mode = 1;
                   else begin ed.push_back(b); ek.push_back(2'd0); ref_crc = crc_step(ref_crc, b); run = 0; end
                1: begin
                    mode = 0;
                    if (b == 8'h99) begin
                        ed.push_back(b); ek.push_back(2'd0); ref_crc = crc_step(ref_crc, b); run = 0;
                    end else if (b == 8'hA1 || b == 8'hFB || b == 8'hFE) begin
                        ref_crc = crc_step(run ? ref_crc : 16'hFFFF, b); run = 1;
                        ed.push_back(b); ek.push_back(2'd1);
                    end else if (b == 8'h04) begin
                        ed.push_back(ref_crc[15:8]); ek.push_back(2'd2);
                        ed.push_back(ref_crc[7:0]);  ek.push_back(2'd2);
                        run = 0;
                    end else if (b == 8'h08) mode = 3;
                    else if (b == 8'h0F) begin mode = 2; cnt = 0; end
                    else e_err++;
                end
                2: begin
                    ed.push_back(b); ek.push_back(2'd0); ref_crc = crc_step(ref_crc, b); run = 0;
                    cnt++;
                    if (cnt == RAW_LEN) mode = 0;
                end
                default: ;
            endcase
        end
    endtask

    task automatic run_stream(input string tag);
        int idx = 0;
        int idle = 0;
        build_expect();
        gd.delete(); gk.delete(); g_err = 0;
        @(negedge clk);
        check(wr_gate == 1'b0, "R6", "gate before arm", wr_gate, 0);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        #1;
        check(wr_gate == 1'b1, "R6", "gate after arm", wr_gate, 1);
        while (idx < stim.size() || idle < 40) begin
            @(negedge clk);
            if (idx < stim.size()) begin
                out_ready = ($urandom % 4) != 0;
                in_valid  = ($urandom % 5) != 0;
                in_data   = stim[idx];
            end else begin
                out_ready = 1'b1;
                in_valid  = 1'b0;
            end
            #1;
            if (out_valid && out_ready) begin gd.push_back(out_data); gk.push_back(out_kind); end
            if (err_cmd) g_err++;
            if (in_valid && in_ready) idx++;
            if (idx >= stim.size()) idle++;
        end
        in_valid = 1'b0;
        check(gd.size() == ed.size(), "R1", {tag, " output count"}, gd.size(), ed.size());
        for (int i = 0; i < gd.size() && i < ed.size(); i++)
            check(gd[i] == ed[i] && gk[i] == ek[i], kind_req(ek[i]),
                  {tag, " byte {kind,data}"}, {gk[i], gd[i]}, {ek[i], ed[i]});
        check(g_err == e_err, "R8", {tag, " err pulses"}, g_err, e_err);
        check(wr_gate == 1'b0, "R6", {tag, " gate after stop"}, wr_gate, 0);
    endtask

    task automatic put_stop_tail();
        stim.push_back(8'h99); stim.push_back(8'h08);
        stim.push_back(8'h99); stim.push_back(8'hA1);
        stim.push_back(8'h55); stim.push_back(8'h99); stim.push_back(8'h04);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10 reset state
        check(out_valid == 1'b0, "R10", "out_valid", out_valid, 0);
        check(wr_gate == 1'b0,   "R10", "wr_gate", wr_gate, 0);
        check(in_ready == 1'b1,  "R10", "in_ready", in_ready, 1);
        check(err_cmd == 1'b0,   "R10", "err_cmd", err_cmd, 0);

        // R6 input while stopped is dropped
        begin
            int seen = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                out_ready = 1'b1; in_valid = 1'b1;
                in_data = (i % 2 == 0) ? 8'h99 : 8'hA1;
                #1;
                if (out_valid || err_cmd) seen++;
            end
            @(negedge clk); in_valid = 1'b0; #1;
            if (out_valid) seen++;
            check(seen == 0, "R6", "output while stopped", seen, 0);
        end

        // R7 sector-style field with raw payload
        stim.delete();
        repeat (5) stim.push_back(8'h4E);
        repeat (6) stim.push_back(8'h00);
        repeat (3) begin stim.push_back(8'h99); stim.push_back(8'hA1); end
        stim.push_back(8'h99); stim.push_back(8'hFB);
        stim.push_back(8'h99); stim.push_back(8'h0F);
        for (int i = 0; i < RAW_LEN; i++)
            stim.push_back((i % 7 == 0) ? 8'h99 : ((i % 11 == 0) ? 8'h08 : 8'($urandom)));
        stim.push_back(8'h99); stim.push_back(8'h04);
        stim.push_back(8'h4E); stim.push_back(8'h4E);
        put_stop_tail();
        run_stream("R7");

        // R2 literal escape, unknown command, address mark
        stim.delete();
        stim.push_back(8'h99); stim.push_back(8'h99);
        stim.push_back(8'h4E);
        stim.push_back(8'h99); stim.push_back(8'h55);
        stim.push_back(8'h99); stim.push_back(8'hFE);
        stim.push_back(8'h12); stim.push_back(8'h34);
        stim.push_back(8'h99); stim.push_back(8'h04);
        put_stop_tail();
        run_stream("R2");

        // R4 two fields back to back: each first mark presets the CRC
        stim.delete();
        stim.push_back(8'h99); stim.push_back(8'hA1);
        stim.push_back(8'h99); stim.push_back(8'hA1);
        stim.push_back(8'h99); stim.push_back(8'hFE);
        stim.push_back(8'h01);
        stim.push_back(8'h99); stim.push_back(8'h04);
        stim.push_back(8'h99); stim.push_back(8'hA1);
        stim.push_back(8'h99); stim.push_back(8'hFB);
        stim.push_back(8'h02);
        stim.push_back(8'h99); stim.push_back(8'h04);
        stim.push_back(8'h99); stim.push_back(8'h04);
        put_stop_tail();
        run_stream("R4");

        // R9 random streams of tokens
        for (int s = 0; s < 10; s++) begin
            stim.delete();
            for (int t = 0; t < 40; t++) begin
                int r;
                logic [7:0] b;
                r = $urandom % 100;
                if (r < 40) begin
                    b = 8'($urandom);
                    if (b == 8'h99) b = 8'h4E;
                    stim.push_back(b);
                end else if (r < 48) begin
                    stim.push_back(8'h99); stim.push_back(8'h99);
                end else if (r < 68) begin
                    stim.push_back(8'h99);
                    case ($urandom % 3)
                        0: stim.push_back(8'hA1);
                        1: stim.push_back(8'hFB);
                        default: stim.push_back(8'hFE);
                    endcase
                end else if (r < 78) begin
                    stim.push_back(8'h99); stim.push_back(8'h04);
                end else if (r < 88) begin
                    stim.push_back(8'h99);
                    b = 8'($urandom);
                    if (b == 8'h99 || b == 8'hA1 || b == 8'hFB || b == 8'hFE ||
                        b == 8'h04 || b == 8'h08 || b == 8'h0F) b = 8'h33;
                    stim.push_back(b);
                end else if (r < 91) begin
                    stim.push_back(8'h99); stim.push_back(8'h0F);
                    for (int i = 0; i < RAW_LEN; i++) stim.push_back(8'($urandom));
                end else begin
                    stim.push_back(($urandom % 2) ? 8'h4E : 8'h00);
                end
            end
            put_stop_tail();
            run_stream("R9");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule